// File: doc/BRIEF.md
# Split-Stage Pipeline Hazard Controller

This block is the interlock and bypass-select controller for an in-order, single-issue integer pipeline of ten stages. The pipeline is built by cutting each classic stage in half: fetch (F1, F2), decode (D1, D2), execute (X1, X2), memory (M1, M2) and writeback (W1, W2). A result can leave only at the end of a stage pair (the X2, M2 or W2 output). It can enter only at the start of a pair. Because of this, even two dependent ALU operations issued back to back are one cycle apart. Load consumers wait longer.

The decision for each instruction is made while it sits in D2, the cycle before it enters X1. The controller looks at the back-end stages X1 through W1 (valid, write enable, kind, destination register). If an operand is not yet reachable, it raises `stall`. The front end then holds F1..D2 and a bubble goes into X1. Otherwise it registers a bypass select that applies while the instruction is in X1. A W2 producer needs no bypass for a D2 reader, because the register file writes before it reads.

A store's data operand is needed only at M1. It therefore has a second select, registered while the store is in X2. Branches are predicted taken and resolved in D2. A branch waits until its producers have written the register file. If the branch turns out not taken, `flush` kills the younger instructions in F1..D1 and fetch is redirected to the fall-through path on the next cycle.

Top module: `split_pipe_hazard_ctrl`

## Requirements
- R1: While `rst_n` is low, `fwd_a_sel`, `fwd_b_sel` and `st_data_sel` are 0 after each clock edge.
- R2: An ALU producer (kind 0) whose result matches a D2 source stalls that source while the producer is in X1 (position 0). From X2 onward it causes no stall.
- R3: A load producer (kind 1) stalls a dependent D2 source while the load is in X1, X2 or M1 (positions 0..2). A load followed at once by its consumer therefore costs three stall cycles.
- R4: When D2 holds a valid instruction and `stall` is low, the edge writes the operand selects for X1 as follows: 0 means the register file, and 1, 2, 3, 4 mean the producer that was at back-end position 1, 2, 3, 4 (X2, M1, M2, W1) and is now one stage further on.
- R5: When several back-end stages write the same register, the youngest one (lowest position) decides both the stall and the select.
- R6: Register 0 is never a dependency. A stage with `be_valid` or `be_we` low is ignored.
- R7: The data source (src2) of a store (kind 2) never stalls on an ALU producer. It stalls only on a load at position 0. Its X1 select is filled in only from producers whose value is already out.
- R8: While a store is valid in X2, the edge writes `st_data_sel` from the youngest producer of the store's data register at M1, M2 or W1: codes 1, 2, 3 respectively, and 0 otherwise.
- R9: A branch (kind 3) in D2 stalls while any matching producer is in X1..W1.
- R10: `flush` is high exactly when D2 holds a valid branch that is not stalled and `id2_br_taken` is low.
- R11: After a cycle with `stall` high, both operand selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| be_valid | input | 5 | Valid per back-end stage, bit p = position p (0 X1, 1 X2, 2 M1, 3 M2, 4 W1) |
| be_we | input | 5 | Register write enable per back-end stage |
| be_kind | input | 10 | Two-bit kind per stage (0 ALU, 1 load, 2 store, 3 branch) |
| be_dst | input | 25 | Five-bit destination register per stage |
| id2_valid | input | 1 | D2 holds an instruction |
| id2_kind | input | 2 | Kind of the D2 instruction |
| id2_src1 | input | 5 | First source register of D2 (0 = unused) |
| id2_src2 | input | 5 | Second source register of D2 (0 = unused) |
| ex2_src2 | input | 5 | Data source register of the instruction in X2 |
| id2_br_taken | input | 1 | Actual outcome of the D2 branch |
| stall | output | 1 | Hold F1..D2 and send a bubble to X1 |
| flush | output | 1 | Kill F1..D1 and redirect fetch to the fall-through path |
| fwd_a_sel | output | 3 | X1 bypass select for operand A |
| fwd_b_sel | output | 3 | X1 bypass select for operand B |
| st_data_sel | output | 2 | M1 bypass select for store data |

## Verification
The bench sweeps each producer kind across every back-end position against each consumer form (ALU source, store address, store data, branch). It compares stall, flush and the registered selects with values worked out from the ready positions. Several design faults are targeted. An off-by-one ready position would drop or add a load-use stall cycle. Taking the oldest match instead of the youngest would forward stale data. Letting store data stall on an ALU producer would cost a needless bubble. A missing store-data select at M1 would write stale memory data. Further cases cover register 0, write enable low, the flush gating under stall, and selects held at zero during reset.

// File: rtl/phz_pkg.sv
package phz_pkg;
  localparam int NB    = 5;           // back-end positions X1..W1
  localparam int POS_W = $clog2(NB);

  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_LOAD   = 2'd1,
    KIND_STORE  = 2'd2,
    KIND_BRANCH = 2'd3
  } kind_e;

  typedef logic [POS_W-1:0] pos_t;

  // Position whose pair-end output first carries the result.
  function automatic pos_t ready_pos(kind_e k);
    return (k == KIND_LOAD) ? pos_t'(3) : pos_t'(1);
  endfunction

  // Consumer needs the value at X1 input one cycle later.
  function automatic logic exec_stall(kind_e k, pos_t p);
    return p < ready_pos(k);
  endfunction

  // Store data is needed at M1 input, three cycles later.
  function automatic logic sdata_stall(kind_e k, pos_t p);
    return ({1'b0, p} + 4'd2) < {1'b0, ready_pos(k)};
  endfunction

  // Select code for X1: producer one stage further on.
  function automatic logic [2:0] exec_sel(kind_e k, pos_t p);
    return (p >= ready_pos(k)) ? 3'(p) : 3'd0;
  endfunction
endpackage

// File: rtl/phz_scan.sv
module phz_scan
  import phz_pkg::*;
#(
  parameter int N    = 5,
  parameter int RW   = 5,
  parameter int PW   = 3
) (
  input  logic [N-1:0]    valid,
  input  logic [N-1:0]    we,
  input  logic [2*N-1:0]  kind,
  input  logic [N*RW-1:0] dst,
  input  logic [RW-1:0]   src,
  output logic            hit,
  output logic [PW-1:0]   pos,
  output kind_e           hit_kind
);
  always_comb begin
    hit      = 1'b0;
    pos      = '0;
    hit_kind = KIND_ALU;
    // oldest first, so the youngest match is written last
    for (int i = N-1; i >= 0; i--) begin
      if (valid[i] && we[i] && (src != '0) && (dst[i*RW +: RW] == src)) begin
        hit      = 1'b1;
        pos      = PW'(i);
        hit_kind = kind_e'(kind[2*i +: 2]);
      end
    end
  end
endmodule

// File: rtl/phz_issue.sv
module phz_issue
  import phz_pkg::*;
(
  input  logic       id2_valid,
  input  kind_e      id2_kind,
  input  logic       hit_a,
  input  pos_t       pos_a,
  input  kind_e      kind_a,
  input  logic       hit_b,
  input  pos_t       pos_b,
  input  kind_e      kind_b,
  output logic       stall,
  output logic [2:0] sel_a_nxt,
  output logic [2:0] sel_b_nxt
);
  logic is_store, is_branch, stall_a, stall_b;

  always_comb begin
    is_branch = (id2_kind == KIND_BRANCH);
    is_store  = (id2_kind == KIND_STORE);
    stall_a   = hit_a && (is_branch || exec_stall(kind_a, pos_a));
    if (is_branch)     stall_b = hit_b;
    else if (is_store) stall_b = hit_b && sdata_stall(kind_b, pos_b);
    else               stall_b = hit_b && exec_stall(kind_b, pos_b);
    stall     = id2_valid && (stall_a || stall_b);
    sel_a_nxt = (id2_valid && !stall && hit_a) ? exec_sel(kind_a, pos_a) : 3'd0;
    sel_b_nxt = (id2_valid && !stall && hit_b) ? exec_sel(kind_b, pos_b) : 3'd0;
  end
endmodule

// File: rtl/phz_lane.sv
module phz_lane
  import phz_pkg::*;
#(
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ex2_store,
  input  logic          hit,
  input  logic [PW-1:0] pos,
  output logic [1:0]    st_data_sel
);
  logic [1:0] nxt;
  assign nxt = (ex2_store && hit) ? (2'(pos) + 2'd1) : 2'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_data_sel <= 2'd0;
    else        st_data_sel <= nxt;
  end

  // store-data select only follows a store seen in X2
  assert_lane_after_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_data_sel != 2'd0) |-> $past(ex2_store));
endmodule

// File: rtl/split_pipe_hazard_ctrl.sv
module split_pipe_hazard_ctrl
  import phz_pkg::*;
#(
  parameter int REG_W = 5,
  localparam int LANE_N = NB - 2,
  localparam int LANE_W = $clog2(LANE_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NB-1:0]     be_valid,
  input  logic [NB-1:0]     be_we,
  input  logic [2*NB-1:0]   be_kind,
  input  logic [NB*REG_W-1:0] be_dst,
  input  logic              id2_valid,
  input  logic [1:0]        id2_kind,
  input  logic [REG_W-1:0]  id2_src1,
  input  logic [REG_W-1:0]  id2_src2,
  input  logic [REG_W-1:0]  ex2_src2,
  input  logic              id2_br_taken,
  output logic              stall,
  output logic              flush,
  output logic [2:0]        fwd_a_sel,
  output logic [2:0]        fwd_b_sel,
  output logic [1:0]        st_data_sel
);
  logic  hit_a, hit_b, hit_l;
  pos_t  pos_a, pos_b;
  kind_e kind_a, kind_b, kind_l;
  logic [LANE_W-1:0] pos_l;
  logic [2:0] sel_a_nxt, sel_b_nxt;
  logic ex2_store, id2_is_branch;

  phz_scan #(.N(NB), .RW(REG_W), .PW(POS_W)) u_scan_a (
    .valid(be_valid), .we(be_we), .kind(be_kind), .dst(be_dst), .src(id2_src1),
    .hit(hit_a), .pos(pos_a), .hit_kind(kind_a));

  phz_scan #(.N(NB), .RW(REG_W), .PW(POS_W)) u_scan_b (
    .valid(be_valid), .we(be_we), .kind(be_kind), .dst(be_dst), .src(id2_src2),
    .hit(hit_b), .pos(pos_b), .hit_kind(kind_b));

  // store lane looks at M1..W1 only (positions 2..4)
  phz_scan #(.N(LANE_N), .RW(REG_W), .PW(LANE_W)) u_scan_l (
    .valid(be_valid[NB-1:2]), .we(be_we[NB-1:2]), .kind(be_kind[2*NB-1:4]),
    .dst(be_dst[NB*REG_W-1:2*REG_W]), .src(ex2_src2),
    .hit(hit_l), .pos(pos_l), .hit_kind(kind_l));

  phz_issue u_issue (
    .id2_valid(id2_valid), .id2_kind(kind_e'(id2_kind)),
    .hit_a(hit_a), .pos_a(pos_a), .kind_a(kind_a),
    .hit_b(hit_b), .pos_b(pos_b), .kind_b(kind_b),
    .stall(stall), .sel_a_nxt(sel_a_nxt), .sel_b_nxt(sel_b_nxt));

  assign ex2_store = be_valid[1] && (kind_e'(be_kind[3:2]) == KIND_STORE);

  phz_lane #(.PW(LANE_W)) u_lane (
    .clk(clk), .rst_n(rst_n), .ex2_store(ex2_store),
    .hit(hit_l), .pos(pos_l), .st_data_sel(st_data_sel));

  assign id2_is_branch = (kind_e'(id2_kind) == KIND_BRANCH);
  assign flush = id2_valid && id2_is_branch && !stall && !id2_br_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_a_sel <= 3'd0;
      fwd_b_sel <= 3'd0;
    end else begin
      fwd_a_sel <= sel_a_nxt;
      fwd_b_sel <= sel_b_nxt;
    end
  end

  // lane kind is not needed: a load cannot be the youngest M1 match for X2 store
  logic unused_lane_kind;
  assign unused_lane_kind = ^kind_l;

  assert_stall_needs_id2_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> id2_valid);
  assert_bubble_sel_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (fwd_a_sel == 3'd0 && fwd_b_sel == 3'd0));
  assert_sel_from_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel != 3'd0) |-> $past(id2_valid && !stall));
  assert_sel_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a_sel <= 3'd4) && (fwd_b_sel <= 3'd4));
  assert_flush_not_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!stall && id2_valid && id2_is_branch));
endmodule

// File: tb/split_pipe_hazard_ctrl_test.sv
module split_pipe_hazard_ctrl_test;
  localparam int NB = 5;
  localparam int RW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NB-1:0] be_valid, be_we;
  logic [2*NB-1:0] be_kind;
  logic [NB*RW-1:0] be_dst;
  logic id2_valid, id2_br_taken;
  logic [1:0] id2_kind;
  logic [RW-1:0] id2_src1, id2_src2, ex2_src2;
  logic stall, flush;
  logic [2:0] fwd_a_sel, fwd_b_sel;
  logic [1:0] st_data_sel;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;  // 50 MHz

  split_pipe_hazard_ctrl uut (
    .clk(clk), .rst_n(rst_n), .be_valid(be_valid), .be_we(be_we),
    .be_kind(be_kind), .be_dst(be_dst), .id2_valid(id2_valid),
    .id2_kind(id2_kind), .id2_src1(id2_src1), .id2_src2(id2_src2),
    .ex2_src2(ex2_src2), .id2_br_taken(id2_br_taken), .stall(stall),
    .flush(flush), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
    .st_data_sel(st_data_sel));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_all();
    be_valid = '0; be_we = '0; be_kind = '0; be_dst = '0;
    id2_valid = 0; id2_kind = 0; id2_src1 = 0; id2_src2 = 0;
    ex2_src2 = 0; id2_br_taken = 1;
  endtask

  task automatic put(input int p, input int k, input int d, input bit w);
    be_valid[p] = 1'b1; be_we[p] = w;
    be_kind[2*p +: 2] = 2'(k); be_dst[RW*p +: RW] = RW'(d);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    clear_all();
    // R1: a case that would select 1 if not held in reset
    put(1, 0, 7, 1); id2_valid = 1; id2_src1 = 7; id2_src2 = 7;
    be_valid[1] = 1; ex2_src2 = 7; be_kind[3:2] = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 fwd_a_sel in reset", fwd_a_sel, 0);
    chk("R1 fwd_b_sel in reset", fwd_b_sel, 0);
    chk("R1 st_data_sel in reset", st_data_sel, 0);
    rst_n = 1'b1;

    // Sweep: producer kind x consumer form x producer position (5 = none)
    for (int pk = 0; pk < 2; pk++) begin
      for (int form = 0; form < 4; form++) begin
        for (int s = 0; s <= NB; s++) begin
          int ready, exp_stall, exp_a, exp_b, exp_fl;
          @(negedge clk);
          clear_all();
          id2_br_taken = 0;
          if (s < NB) put(s, pk, 7, 1);
          id2_valid = 1;
          case (form)
            0: begin id2_kind = 2'd0; id2_src1 = 7; end
            1: begin id2_kind = 2'd2; id2_src1 = 7; end
            2: begin id2_kind = 2'd2; id2_src2 = 7; end
            default: begin id2_kind = 2'd3; id2_src1 = 7; end
          endcase
          // value exits after X2 (ALU) or after M2 (load)
          ready = (pk == 1) ? 3 : 1;
          if (s >= NB) exp_stall = 0;
          else if (form == 3) exp_stall = 1;
          else if (form == 2) exp_stall = (s + 2 < ready) ? 1 : 0;
          else exp_stall = (s < ready) ? 1 : 0;
          exp_a = 0; exp_b = 0;
          if (!exp_stall && s < NB && s >= ready) begin
            if (form == 2) exp_b = s; else exp_a = s;
          end
          exp_fl = (form == 3 && !exp_stall) ? 1 : 0;
          #2;
          if (pk == 1) chk("R3 load-use stall", stall, exp_stall);
          else if (form == 2) chk("R7 store data stall", stall, exp_stall);
          else if (form == 3) chk("R9 branch stall", stall, exp_stall);
          else chk("R2 alu-use stall", stall, exp_stall);
          chk("R10 flush on not-taken", flush, exp_fl);
          @(negedge clk);
          if (exp_stall) begin
            chk("R11 bubble fwd_a", fwd_a_sel, 0);
            chk("R11 bubble fwd_b", fwd_b_sel, 0);
          end else begin
            chk("R4 fwd_a_sel", fwd_a_sel, exp_a);
            chk(form == 2 ? "R7 store fwd_b_sel" : "R4 fwd_b_sel", fwd_b_sel, exp_b);
          end
        end
      end
    end

    // R5: two ALU writers of r7 at X2 and M2: younger (X2) wins
    @(negedge clk); clear_all();
    put(3, 0, 7, 1); put(1, 0, 7, 1); id2_valid = 1; id2_src1 = 7;
    #2 chk("R5 no stall", stall, 0);
    @(negedge clk); chk("R5 youngest select", fwd_a_sel, 1);

    // R5: younger load at X2 hides older ready ALU at M2 -> stall
    @(negedge clk); clear_all();
    put(3, 0, 7, 1); put(1, 1, 7, 1); id2_valid = 1; id2_src1 = 7;
    #2 chk("R5 younger load stalls", stall, 1);

    // R6: destination register 0 is not a dependency
    @(negedge clk); clear_all();
    put(0, 1, 0, 1); id2_valid = 1; id2_src1 = 0; id2_src2 = 0;
    #2 chk("R6 r0 ignored", stall, 0);

    // R6: write enable low is ignored
    @(negedge clk); clear_all();
    put(0, 0, 7, 0); id2_valid = 1; id2_src1 = 7;
    #2 chk("R6 we low ignored", stall, 0);
    @(negedge clk); chk("R6 we low select", fwd_a_sel, 0);

    // R10: taken branch does not flush
    @(negedge clk); clear_all();
    id2_valid = 1; id2_kind = 2'd3; id2_br_taken = 1;
    #2 chk("R10 taken no flush", flush, 0);

    // R10: invalid D2 never flushes or stalls
    @(negedge clk); clear_all();
    id2_kind = 2'd3; id2_br_taken = 0; put(0, 0, 7, 1); id2_src1 = 7;
    #2 chk("R10 invalid no flush", flush, 0);
    chk("R2 invalid no stall", stall, 0);

    // R8: store in X2, producer of its data at positions 2..4 (M1, M2, W1)
    for (int p = 2; p <= NB; p++) begin
      @(negedge clk); clear_all();
      be_valid[1] = 1; be_kind[3:2] = 2'd2; ex2_src2 = 9;
      if (p < NB) put(p, 0, 9, 1);
      @(negedge clk);
      chk("R8 store data select", st_data_sel, (p < NB) ? p - 1 : 0);
    end

    // R8: same producer but X2 holds an ALU op -> no store select
    @(negedge clk); clear_all();
    be_valid[1] = 1; be_kind[3:2] = 2'd0; ex2_src2 = 9; put(3, 0, 9, 1);
    @(negedge clk);
    chk("R8 non-store no select", st_data_sel, 0);

    @(negedge clk);
    finish_run();
  end
endmodule